// File: doc/BRIEF.md
# I2C Register Target with High-Speed Mode Tracking

This block is a target on a two-wire serial bus with a small bank of byte registers behind it. It runs from a fast system clock and passes the clock and data lines through two-flop synchronisers. It then detects edges and decodes START, repeated START and STOP conditions. After a START, the first byte is either the target's 7-bit address followed by a direction bit, or the high-speed master code. The target never acknowledges the master code, but raises a status flag that marks high-speed operation. That flag survives repeated STARTs and drops on STOP.

In a write transaction, a single device address is followed by any number of pairs: one register-address byte, then one data byte. Each pair updates one register at the SCL falling edge that closes the acknowledge of its data byte. In a read, the master sends a repeated START and then the address with the direction bit set. The target then returns the register selected by the last register address it received, most significant bit first. It keeps sending that register for as long as the master acknowledges. Register addresses outside the bank read as FFh and ignore writes. The bank also has a host-side read port, and each bus write is signalled on a write strobe.

Top module: `i2c_hs_target`

## Requirements
- R1: After reset, SDA is released, the high-speed flag is low and every implemented register holds 00h.
- R2: START (SDA falls while SCL is high) followed by the matching 7-bit device address is acknowledged: SDA is pulled low through the ninth clock's high period. SDA changes only while SCL is low, except when STOP releases it.
- R3: A first byte whose upper 7 bits differ from the device address gets no acknowledge. Every later byte up to the next START or STOP is also ignored: no acknowledge and no register write.
- R4: A first byte whose top five bits are 00001 (the master code) is not acknowledged and sets the high-speed flag.
- R5: A repeated START leaves the high-speed flag set. STOP (SDA rises while SCL is high) clears it.
- R6: After the device address with the direction bit 0, the following bytes alternate between register address and data, and each one is acknowledged. The write strobe fires once per data byte, after the SCL falling edge that ends its acknowledge, and it updates that register.
- R7: After the device address with the direction bit 1, the target sends the register at the last register address, MSB first, changing SDA only while SCL is low. The byte is repeated while the master acknowledges, and an unimplemented address returns FFh.
- R8: A master NACK (SDA high on the ninth clock) of a read byte makes the target release SDA and drive nothing more until START or STOP.
- R9: A STOP partway through a byte aborts the transaction: SDA is released and no register is written.
- R10: The host read port returns the addressed register, or FFh for addresses beyond the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (resolved open-drain level) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| hs_mode_o | output | 1 | High-speed mode flag |
| host_addr_i | input | 8 | Host-side register read address |
| host_rdata_o | output | 8 | Host-side register read data |
| wr_strobe_o | output | 1 | One-cycle pulse when the bus writes a register |
| wr_addr_o | output | 8 | Register address of the bus write |
| wr_data_o | output | 8 | Data of the bus write |

## Verification
A level change on scl_i or sda_i reaches the protocol state machine at the third rising clock edge. The SDA drive, the high-speed flag and the write strobe are all registered at that edge, and the register contents and host read data follow one edge later. The bench's behavioural model updates its expectation at the instant it moves SCL or SDA. It compares the outputs on every clock, but only once eight quiet cycles have passed since its last expectation change. Each bus phase lasts ten cycles, so every phase holds settled cycles that are checked. Acknowledge and read bits are sampled on the resolved line one cycle after the master raises SCL.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SEND,
        ST_MACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          st;
        logic [3:0]          cnt;
        logic [BYTE_W-1:0]   shreg;
        logic                first;
        logic                is_data;
        logic                rw;
        logic [BYTE_W-1:0]   ptr;
        logic                pend_wr;
        logic                sda_low;
        logic                hs;
        logic                wr_en;
        logic [BYTE_W-1:0]   wr_data;
    } fsm_reg_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int TAPS = STAGES + 1;

    typedef struct packed {
        logic [TAPS-1:0] scl;
        logic [TAPS-1:0] sda;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.scl = {sync_q.scl[TAPS-2:0], scl_i};
        sync_d.sda = {sync_q.sda[TAPS-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    logic scl_cur, scl_prev, sda_cur, sda_prev;
    assign scl_cur  = sync_q.scl[TAPS-2];
    assign scl_prev = sync_q.scl[TAPS-1];
    assign sda_cur  = sync_q.sda[TAPS-2];
    assign sda_prev = sync_q.sda[TAPS-1];

    assign scl_o      = scl_cur;
    assign sda_o      = sda_cur;
    assign scl_rise_o = scl_cur & ~scl_prev;
    assign scl_fall_o = ~scl_cur & scl_prev;
    assign start_o    = scl_cur & scl_prev & sda_prev & ~sda_cur;
    assign stop_o     = scl_cur & scl_prev & ~sda_prev & sda_cur;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int          NUM_REGS = 8,
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [7:0]  RST_VAL  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_rdata,
    input  logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_rdata
);
    logic [DW-1:0] regs [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic [DW-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && wr_addr == AW'(gi)) r_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= DW'(RST_VAL);
            else        r_q <= r_d;
        end

        assign regs[gi] = r_q;
    end

    always_comb begin
        bus_rdata  = '1;
        host_rdata = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (bus_addr == AW'(i))  bus_rdata  = regs[i];
            if (host_addr == AW'(i)) host_rdata = regs[i];
        end
    end

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_hs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_low_o,
    output logic              hs_mode_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic [BYTE_W-1:0] rd_addr_o
);
    localparam logic [4:0] MC_PREFIX = 5'b00001;
    localparam logic [3:0] LAST_BIT  = 4'd8;
    localparam logic [3:0] NINTH     = 4'd9;

    fsm_reg_t q, d;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (stop_det) begin
            d.st      = ST_IDLE;
            d.sda_low = 1'b0;
            d.hs      = 1'b0;
            d.pend_wr = 1'b0;
        end else if (start_det) begin
            d.st      = ST_RECV;
            d.cnt     = '0;
            d.first   = 1'b1;
            d.sda_low = 1'b0;
            d.pend_wr = 1'b0;
        end else begin
            case (q.st)
                ST_RECV: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == LAST_BIT) begin
                        if (q.first) begin
                            if (q.shreg[7:3] == MC_PREFIX) begin
                                d.hs = 1'b1;
                                d.st = ST_SKIP;
                            end else if (q.shreg[7:1] == DEV_ADDR) begin
                                d.sda_low = 1'b1;
                                d.st      = ST_ACK;
                                d.rw      = q.shreg[0];
                                d.is_data = 1'b0;
                                d.first   = 1'b0;
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end else begin
                            d.sda_low = 1'b1;
                            d.st      = ST_ACK;
                            if (q.is_data) begin
                                d.pend_wr = 1'b1;
                                d.wr_data = q.shreg;
                                d.is_data = 1'b0;
                            end else begin
                                d.ptr     = q.shreg;
                                d.is_data = 1'b1;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_rise && q.cnt == LAST_BIT) begin
                        d.cnt = NINTH;
                    end else if (scl_fall && q.cnt == NINTH) begin
                        d.cnt     = '0;
                        d.sda_low = 1'b0;
                        if (q.rw) begin
                            d.st      = ST_SEND;
                            d.shreg   = rd_data;
                            d.sda_low = ~rd_data[7];
                        end else begin
                            d.st = ST_RECV;
                            if (q.pend_wr) begin
                                d.wr_en   = 1'b1;
                                d.pend_wr = 1'b0;
                            end
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_rise && q.cnt < LAST_BIT) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt != '0) begin
                        if (q.cnt == LAST_BIT) begin
                            d.sda_low = 1'b0;
                            d.st      = ST_MACK;
                        end else begin
                            d.shreg   = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.sda_low = ~q.shreg[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise && q.cnt == LAST_BIT) begin
                        d.cnt = NINTH;
                        if (sda_s) d.st = ST_SKIP;
                    end else if (scl_fall && q.cnt == NINTH) begin
                        d.cnt     = '0;
                        d.st      = ST_SEND;
                        d.shreg   = rd_data;
                        d.sda_low = ~rd_data[7];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_low_o = q.sda_low;
    assign hs_mode_o = q.hs;
    assign wr_en_o   = q.wr_en;
    assign wr_addr_o = q.ptr;
    assign wr_data_o = q.wr_data;
    assign rd_addr_o = q.ptr;

    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.sda_low);

    p_stop_clears_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !q.hs);

    p_rstart_keeps_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && q.hs) |=> q.hs);

    p_sda_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sda_low) |-> ($past(!scl_s) || $past(stop_det)));

    p_write_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> $past(scl_fall));

    p_hs_set_at_byte_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.hs) |-> $past(scl_fall));

endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low_o,
    output logic       hs_mode_o,
    input  logic [7:0] host_addr_i,
    output logic [7:0] host_rdata_o,
    output logic       wr_strobe_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o
);
    import i2c_hs_pkg::*;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] bus_rdata, bus_raddr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (bus_rdata),
        .sda_low_o (sda_drive_low_o),
        .hs_mode_o (hs_mode_o),
        .wr_en_o   (wr_strobe_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .rd_addr_o (bus_raddr)
    );

    i2c_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .AW       (BYTE_W),
        .DW       (BYTE_W),
        .RST_VAL  (8'h00)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_strobe_o),
        .wr_addr    (wr_addr_o),
        .wr_data    (wr_data_o),
        .bus_addr   (bus_raddr),
        .bus_rdata  (bus_rdata),
        .host_addr  (host_addr_i),
        .host_rdata (host_rdata_o)
    );

endmodule

// File: tb/i2c_hs_target_tb.sv
module i2c_hs_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int SETTLE     = 8;
    localparam int NREG       = 8;
    localparam logic [6:0] DEV = 7'h6A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_drive_low, hs_mode, wr_strobe;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_rdata, wr_addr, wr_data;
    logic sda_line;

    assign sda_line = sda_m & ~sda_drive_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_hs_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .sda_drive_low_o (sda_drive_low),
        .hs_mode_o       (hs_mode),
        .host_addr_i     (host_addr),
        .host_rdata_o    (host_rdata),
        .wr_strobe_o     (wr_strobe),
        .wr_addr_o       (wr_addr),
        .wr_data_o       (wr_data)
    );

    int checks = 0;
    int fails = 0;
    int settle = 0;
    int strobes = 0;
    int exp_strobes = 0;
    bit done = 1'b0;
    bit exp_drive = 1'b0;
    bit exp_hs = 1'b0;
    logic [7:0] mreg [NREG];

    function automatic logic [7:0] model_rd(input logic [7:0] a);
        if (int'(a) < NREG) return mreg[a[2:0]];
        return 8'hFF;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) if (wr_strobe) strobes++;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (settle >= SETTLE) begin
                chk(sda_drive_low == exp_drive, "R2 sda drive", int'(sda_drive_low), int'(exp_drive));
                chk(hs_mode == exp_hs, "R5 hs flag", int'(hs_mode), int'(exp_hs));
                chk(host_rdata == model_rd(host_addr), "R10 host read", int'(host_rdata),
                    int'(model_rd(host_addr)));
            end
            settle++;
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1;
        exp_hs = 1'b0; exp_drive = 1'b0; settle = 0;
        tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack, input string tag,
                             input bit mc, input int wr_idx, input logic [7:0] wr_val,
                             input bit drive_after);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0;
            if (i == 0) begin
                exp_drive = ack;
                if (mc) exp_hs = 1'b1;
                settle = 0;
            end
            tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(1);
        chk(sda_line == !ack, tag, int'(sda_line), int'(!ack));
        tick(2*Q-1);
        scl_m = 1'b0;
        exp_drive = drive_after;
        if (wr_idx >= 0) begin
            exp_strobes++;
            if (wr_idx < NREG) mreg[wr_idx] = wr_val;
        end
        settle = 0;
        tick(Q);
    endtask

    task automatic recv_byte(input logic [7:0] eb, input bit mack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(1);
            chk(sda_line == eb[i], tag, int'(sda_line), int'(eb[i]));
            tick(2*Q-1);
            scl_m = 1'b0;
            exp_drive = (i > 0) ? !eb[i-1] : 1'b0;
            settle = 0;
            tick(Q);
        end
        sda_m = !mack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0;
        exp_drive = mack ? !eb[7] : 1'b0;
        settle = 0;
        tick(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        tick(10);
        rst_n = 1'b1;
        tick(3);
        // R1: reset state
        chk(sda_drive_low == 1'b0, "R1 sda released", int'(sda_drive_low), 0);
        chk(hs_mode == 1'b0, "R1 hs low", int'(hs_mode), 0);
        chk(host_rdata == 8'h00, "R1 reg zero", int'(host_rdata), 0);
        host_addr = 8'h20; settle = 0; tick(2);
        chk(host_rdata == 8'hFF, "R10 unmapped host", int'(host_rdata), 8'hFF);

        // R2 R6: write two registers with pairs after one address
        bus_start();
        send_byte({DEV, 1'b0}, 1, "R2 addr ack", 0, -1, 8'h00, 0);
        send_byte(8'h03, 1, "R6 reg ack", 0, -1, 8'h00, 0);
        send_byte(8'hA5, 1, "R6 data ack", 0, 3, 8'hA5, 0);
        send_byte(8'h05, 1, "R6 reg ack 2", 0, -1, 8'h00, 0);
        send_byte(8'h3C, 1, "R6 data ack 2", 0, 5, 8'h3C, 0);
        bus_stop();
        chk(strobes == exp_strobes, "R6 strobe count", strobes, exp_strobes);
        host_addr = 8'h03; settle = 0; tick(2);
        chk(host_rdata == 8'hA5, "R6 reg3 value", int'(host_rdata), 8'hA5);
        host_addr = 8'h05; settle = 0; tick(2);
        chk(host_rdata == 8'h3C, "R10 reg5 value", int'(host_rdata), 8'h3C);

        // R3: other address ignored
        bus_start();
        send_byte({7'h55, 1'b0}, 0, "R3 no ack addr", 0, -1, 8'h00, 0);
        send_byte(8'h05, 0, "R3 no ack reg", 0, -1, 8'h00, 0);
        send_byte(8'hEE, 0, "R3 no ack data", 0, -1, 8'h00, 0);
        bus_stop();
        chk(strobes == exp_strobes, "R3 no write", strobes, exp_strobes);
        chk(host_rdata == 8'h3C, "R3 reg5 kept", int'(host_rdata), 8'h3C);

        // R4 R5 R7 R8: master code, HS transaction, read
        bus_start();
        send_byte(8'h0B, 0, "R4 mc no ack", 1, -1, 8'h00, 0);
        chk(hs_mode == 1'b1, "R4 hs set", int'(hs_mode), 1);
        bus_start();
        chk(hs_mode == 1'b1, "R5 hs after rstart", int'(hs_mode), 1);
        send_byte({DEV, 1'b0}, 1, "R2 hs addr ack", 0, -1, 8'h00, 0);
        send_byte(8'h02, 1, "R6 hs reg ack", 0, -1, 8'h00, 0);
        send_byte(8'h77, 1, "R6 hs data ack", 0, 2, 8'h77, 0);
        bus_start();
        send_byte({DEV, 1'b1}, 1, "R7 read addr ack", 0, -1, 8'h00, !mreg[2][7]);
        recv_byte(8'h77, 1, "R7 read bit");
        recv_byte(8'h77, 0, "R7 repeat read bit");
        chk(sda_drive_low == 1'b0, "R8 released after nack", int'(sda_drive_low), 0);
        chk(hs_mode == 1'b1, "R5 hs kept", int'(hs_mode), 1);
        bus_stop();
        tick(SETTLE);
        chk(hs_mode == 1'b0, "R5 hs cleared", int'(hs_mode), 0);

        // R7: unmapped register read
        bus_start();
        send_byte({DEV, 1'b0}, 1, "R2 addr ack 3", 0, -1, 8'h00, 0);
        send_byte(8'h40, 1, "R7 reg ack", 0, -1, 8'h00, 0);
        bus_start();
        send_byte({DEV, 1'b1}, 1, "R7 read addr ack 2", 0, -1, 8'h00, 0);
        recv_byte(8'hFF, 0, "R7 unmapped bit");
        bus_stop();

        // R9: STOP partway through a data byte
        bus_start();
        send_byte({DEV, 1'b0}, 1, "R2 addr ack 4", 0, -1, 8'h00, 0);
        send_byte(8'h04, 1, "R9 reg ack", 0, -1, 8'h00, 0);
        for (int i = 0; i < 4; i++) begin
            sda_m = i[0]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        bus_stop();
        tick(SETTLE);
        chk(sda_drive_low == 1'b0, "R9 released", int'(sda_drive_low), 0);
        chk(strobes == exp_strobes, "R9 no write", strobes, exp_strobes);
        host_addr = 8'h04; settle = 0; tick(2);
        chk(host_rdata == 8'h00, "R9 reg4 unchanged", int'(host_rdata), 0);
        bus_start();
        send_byte({DEV, 1'b0}, 1, "R9 recovery ack", 0, -1, 8'h00, 0);
        send_byte(8'h04, 1, "R6 reg ack 5", 0, -1, 8'h00, 0);
        send_byte(8'h81, 1, "R6 data ack 5", 0, 4, 8'h81, 0);
        bus_stop();
        tick(SETTLE);
        chk(host_rdata == 8'h81, "R6 reg4 written", int'(host_rdata), 8'h81);
        chk(strobes == exp_strobes, "R6 final strobes", strobes, exp_strobes);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule